// File: doc/BRIEF.md
# External and Pin-Change Interrupt Controller

This block watches one dedicated external interrupt input and sixteen general-purpose input pins, and turns activity on them into a single interrupt request toward a processor core. The external input has a two-bit sense selection: low level, any change, falling edge or rising edge. In the three edge modes, a detected event latches a request flag. In level mode, no flag is kept and the request follows the pin.

The sixteen general pins form two groups of eight. Each group has an eight-bit enable mask, a group enable and one shared flag. A change on a pin latches its group's flag only when both the pin's mask bit and the group enable are one. A software register port reads and writes the control word, the flags and the masks. Flags clear on a write of one, or when the core acknowledges the matching vector. The request output is gated by a global enable input. The vector index output names the highest-priority pending source.

All pin inputs pass through a two-flop synchronizer. Edges are found by comparing the synchronized value with its value one cycle earlier.

Top module: `pin_irq_ctrl`

## Requirements
- R1: In the edge sense modes, the external flag (flag register at address 1, bit 0) sets on the chosen event. The modes are code 01 for any change, 10 for a falling edge and 11 for a rising edge. The sense code sits in control register (address 0) bits 2:1. The flag is set two clock edges after the edge that first samples the pin.
- R2: `irq_req` is high only when `gie` is one and a pending source also has its own enable set. The enables are control bit 0 for the external pin and bit 3+g for group g. `irq_req` is registered, so it follows a pending source one clock edge later.
- R3: An `ack` pulse clears only the flag selected by `ack_vec`: 0 for the external pin, 1 for group 0, 2 for group 1. The other flags keep their values.
- R4: Writing the flag register clears each flag whose data bit is one. A data bit of zero leaves its flag unchanged.
- R5: In sense mode 00 (low level), the external flag always reads zero. The external request is then the synchronized pin being low, and it reaches `irq_req` two edges after the sampling edge.
- R6: After reset, the control register, the flag register and both mask registers (group 0 at address 2, group 1 at address 3) all read zero, and `irq_req` is low.
- R7: A change on `pc_pins[8*g+b]` sets the group g flag (flag register bit 1+g) only when bit b of group g's mask is one and the group g enable is one.
- R8: With several sources pending, the vector order is external pin (0), then group 0 (1), then group 1 (2).
- R9: Values written to the control register and the mask registers read back unchanged, one edge after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gie | input | 1 | Global interrupt enable from the core |
| ext_pin | input | 1 | External interrupt input (asynchronous) |
| pc_pins | input | 16 | Pin-change inputs, group 0 in bits 7:0, group 1 in bits 15:8 |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data for `reg_addr` |
| ack | input | 1 | Core acknowledges that a vector is being executed |
| ack_vec | input | 2 | Vector index being acknowledged |
| irq_req | output | 1 | Registered interrupt request |
| irq_vec | output | 2 | Registered vector index of highest-priority pending source |

## Verification
A pin change driven between edges is sampled at the next edge, k. The resulting flag is set at edge k+2, it is visible on `reg_rdata` after edge k+3, and the edge-driven `irq_req` rises at edge k+3. A level request reaches `irq_req` at edge k+2. An `ack` or a flag write takes effect at its own edge, and `irq_req` and `irq_vec` follow one edge later. The bench drives inputs on falling clock edges and samples only after exactly the number of rising edges listed above. This way each check lands in the first cycle the result is due.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;

  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_ANY  = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_RISE = 2'b11
  } sense_e;

  localparam int unsigned ADDR_CTRL  = 0;
  localparam int unsigned ADDR_FLAG  = 1;
  localparam int unsigned ADDR_MASK0 = 2;

  localparam int unsigned CTRL_EXT_EN  = 0;
  localparam int unsigned CTRL_SENSE_LO = 1;
  localparam int unsigned CTRL_GRP_EN0 = 3;

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int unsigned W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] cur,
  output logic [W-1:0] prev
);

  logic [W-1:0] meta_q, cur_q, prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      cur_q  <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pin_in;
      cur_q  <= meta_q;
      prev_q <= cur_q;
    end
  end

  assign cur  = cur_q;
  assign prev = prev_q;

endmodule

// File: rtl/ext_sense.sv
module ext_sense
  import pin_irq_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  sense_e sense,
  input  logic   cur,
  input  logic   prev,
  input  logic   w1c,
  input  logic   ack,
  output logic   flag,
  output logic   level_req
);

  logic set;
  logic flag_q;

  always_comb begin
    unique case (sense)
      SENSE_ANY:  set = cur ^ prev;
      SENSE_FALL: set = prev & ~cur;
      SENSE_RISE: set = ~prev & cur;
      default:    set = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)                    flag_q <= 1'b0;
    else if (sense == SENSE_LOW) flag_q <= 1'b0;
    else if (set)               flag_q <= 1'b1;
    else if (w1c || ack)        flag_q <= 1'b0;
  end

  assign flag      = flag_q;
  assign level_req = (sense == SENSE_LOW) & ~cur;

  AST_LEVEL_NO_FLAG: assert property (@(posedge clk) disable iff (rst)
    (sense == SENSE_LOW) |=> !flag_q); // R5
  AST_EDGE_SETS: assert property (@(posedge clk) disable iff (rst)
    (set && sense != SENSE_LOW) |=> flag_q); // R1
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (w1c && !set) |=> !flag_q); // R4
  AST_W0_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !w1c && !ack && sense != SENSE_LOW) |=> flag_q); // R4
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (ack && !set) |=> !flag_q); // R3

endmodule

// File: rtl/pc_group.sv
module pc_group #(
  parameter int unsigned GW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          grp_en,
  input  logic [GW-1:0] mask,
  input  logic [GW-1:0] cur,
  input  logic [GW-1:0] prev,
  input  logic          w1c,
  input  logic          ack,
  output logic          flag
);

  logic [GW-1:0] hit;
  logic          set;
  logic          flag_q;

  assign hit = (cur ^ prev) & mask;
  assign set = grp_en & (|hit);

  always_ff @(posedge clk) begin
    if (rst)             flag_q <= 1'b0;
    else if (set)        flag_q <= 1'b1;
    else if (w1c || ack) flag_q <= 1'b0;
  end

  assign flag = flag_q;

  AST_GRP_DISABLED: assert property (@(posedge clk) disable iff (rst)
    (!grp_en && !flag_q) |=> !flag_q); // R7
  AST_GRP_MASKED: assert property (@(posedge clk) disable iff (rst)
    (mask == '0 && !flag_q) |=> !flag_q); // R7
  AST_GRP_CLEAR: assert property (@(posedge clk) disable iff (rst)
    ((w1c || ack) && !set) |=> !flag_q); // R3

endmodule

// File: rtl/irq_arb.sv
module irq_arb #(
  parameter int unsigned NSRC  = 3,
  parameter int unsigned VEC_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             gie,
  input  logic [NSRC-1:0]  pend,
  output logic             irq_req,
  output logic [VEC_W-1:0] irq_vec
);

  logic [VEC_W-1:0] vec_d;
  logic             req_q;
  logic [VEC_W-1:0] vec_q;

  always_comb begin
    vec_d = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (pend[i]) vec_d = VEC_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q <= 1'b0;
      vec_q <= '0;
    end else begin
      req_q <= gie & (|pend);
      vec_q <= vec_d;
    end
  end

  assign irq_req = req_q;
  assign irq_vec = vec_q;

  AST_NO_REQ_WITHOUT_GIE: assert property (@(posedge clk) disable iff (rst)
    !gie |=> !irq_req); // R2
  AST_EXT_FIRST: assert property (@(posedge clk) disable iff (rst)
    (gie && pend[0]) |=> (irq_req && irq_vec == '0)); // R8
  AST_VEC_RANGE: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> (int'(irq_vec) < NSRC)); // R8

endmodule

// File: rtl/pin_irq_ctrl.sv
module pin_irq_ctrl
  import pin_irq_pkg::*;
#(
  parameter int unsigned GROUP_W    = 8,
  parameter int unsigned NUM_GROUPS = 2,
  parameter int unsigned ADDR_W     = 3,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned VEC_W      = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          gie,
  input  logic                          ext_pin,
  input  logic [GROUP_W*NUM_GROUPS-1:0] pc_pins,
  input  logic                          reg_we,
  input  logic [ADDR_W-1:0]             reg_addr,
  input  logic [DATA_W-1:0]             reg_wdata,
  output logic [DATA_W-1:0]             reg_rdata,
  input  logic                          ack,
  input  logic [VEC_W-1:0]              ack_vec,
  output logic                          irq_req,
  output logic [VEC_W-1:0]              irq_vec
);

  localparam int unsigned NPC  = GROUP_W * NUM_GROUPS;
  localparam int unsigned NSRC = NUM_GROUPS + 1;
  localparam int unsigned CTRL_BITS = CTRL_GRP_EN0 + NUM_GROUPS;
  localparam logic [DATA_W-1:0] CTRL_USED = DATA_W'((1 << CTRL_BITS) - 1);

  logic [DATA_W-1:0]  ctrl_q;
  logic [GROUP_W-1:0] mask_q [NUM_GROUPS];
  logic [NSRC-1:0]    flags;
  logic [NSRC-1:0]    w1c;
  logic [NSRC-1:0]    ackv;
  logic [NSRC-1:0]    pend;
  logic [DATA_W-1:0]  rdata_d;
  logic [DATA_W-1:0]  rdata_q;
  logic               ext_cur, ext_prev, level_req;
  logic [NPC-1:0]     pc_cur, pc_prev;
  sense_e             sense;

  assign sense = sense_e'(ctrl_q[CTRL_SENSE_LO +: 2]);

  // control and mask registers
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      for (int g = 0; g < NUM_GROUPS; g++) mask_q[g] <= '0;
    end else if (reg_we) begin
      if (int'(reg_addr) == ADDR_CTRL) ctrl_q <= reg_wdata & CTRL_USED;
      for (int g = 0; g < NUM_GROUPS; g++) begin
        if (int'(reg_addr) == ADDR_MASK0 + g) mask_q[g] <= reg_wdata[GROUP_W-1:0];
      end
    end
  end

  // flag clears: write-one and acknowledge
  always_comb begin
    for (int s = 0; s < NSRC; s++) begin
      w1c[s]  = reg_we && (int'(reg_addr) == ADDR_FLAG) && reg_wdata[s];
      ackv[s] = ack && (int'(ack_vec) == s);
    end
  end

  // read mux, registered
  always_comb begin
    rdata_d = '0;
    if (int'(reg_addr) == ADDR_CTRL) rdata_d = ctrl_q;
    if (int'(reg_addr) == ADDR_FLAG) rdata_d = DATA_W'(flags);
    for (int g = 0; g < NUM_GROUPS; g++) begin
      if (int'(reg_addr) == ADDR_MASK0 + g) rdata_d = DATA_W'(mask_q[g]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rdata_d;
  end

  assign reg_rdata = rdata_q;

  pin_sync #(.W(1)) u_ext_sync (
    .clk(clk), .rst(rst), .pin_in(ext_pin), .cur(ext_cur), .prev(ext_prev)
  );

  pin_sync #(.W(NPC)) u_pc_sync (
    .clk(clk), .rst(rst), .pin_in(pc_pins), .cur(pc_cur), .prev(pc_prev)
  );

  ext_sense u_ext (
    .clk(clk), .rst(rst), .sense(sense), .cur(ext_cur), .prev(ext_prev),
    .w1c(w1c[0]), .ack(ackv[0]), .flag(flags[0]), .level_req(level_req)
  );

  assign pend[0] = ctrl_q[CTRL_EXT_EN] & (flags[0] | level_req);

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    pc_group #(.GW(GROUP_W)) u_grp (
      .clk   (clk),
      .rst   (rst),
      .grp_en(ctrl_q[CTRL_GRP_EN0 + g]),
      .mask  (mask_q[g]),
      .cur   (pc_cur[g*GROUP_W +: GROUP_W]),
      .prev  (pc_prev[g*GROUP_W +: GROUP_W]),
      .w1c   (w1c[g+1]),
      .ack   (ackv[g+1]),
      .flag  (flags[g+1])
    );
    assign pend[g+1] = ctrl_q[CTRL_GRP_EN0 + g] & flags[g+1];
  end

  irq_arb #(.NSRC(NSRC), .VEC_W(VEC_W)) u_arb (
    .clk(clk), .rst(rst), .gie(gie), .pend(pend),
    .irq_req(irq_req), .irq_vec(irq_vec)
  );

  AST_WRITE_READBACK: assert property (@(posedge clk) disable iff (rst)
    (reg_we && int'(reg_addr) == ADDR_MASK0) |=> (mask_q[0] == $past(reg_wdata[GROUP_W-1:0]))); // R9

endmodule

// File: tb/pin_irq_ctrl_tb.sv
module pin_irq_ctrl_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        gie = 1'b0;
  logic        ext_pin = 1'b0;
  logic [15:0] pc_pins = '0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        ack = 1'b0;
  logic [1:0]  ack_vec = '0;
  logic        irq_req;
  logic [1:0]  irq_vec;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pin_irq_ctrl u_dut (
    .clk(clk), .rst(rst), .gie(gie), .ext_pin(ext_pin), .pc_pins(pc_pins),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .ack(ack), .ack_vec(ack_vec),
    .irq_req(irq_req), .irq_vec(irq_vec)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    reg_we = 1'b1; reg_addr = 3'(a); reg_wdata = 8'(d);
    step(1);
    reg_we = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    reg_addr = 3'(a);
    step(1);
    d = int'(reg_rdata);
  endtask

  task automatic pulse_ack(input int v);
    ack = 1'b1; ack_vec = 2'(v);
    step(1);
    ack = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int v;
    step(4);
    rst = 1'b0;
    step(1);

    // R6: reset state
    for (int a = 0; a < 4; a++) begin
      rd(a, v);
      chk("R6 reset value", v, 0);
    end
    chk("R6 irq_req after reset", int'(irq_req), 0);

    // R9: readback
    wr(2, 8'hA5); wr(3, 8'h3C); wr(0, 8'h1B);
    rd(2, v); chk("R9 mask0 readback", v, 8'hA5);
    rd(3, v); chk("R9 mask1 readback", v, 8'h3C);
    rd(0, v); chk("R9 ctrl readback", v, 8'h1B);
    wr(2, 0); wr(3, 0);

    // R1/R2: edge modes, both directions
    gie = 1'b1;
    for (int m = 1; m < 4; m++) begin
      for (int s = 0; s < 2; s++) begin
        int e;
        wr(0, 1 | (m << 1));
        ext_pin = s[0];
        step(4);
        wr(1, 1);
        ext_pin = ~s[0];
        step(3);
        rd(1, v);
        e = (m == 1) || (m == 2 && s == 1) || (m == 3 && s == 0) ? 1 : 0;
        chk($sformatf("R1 ext flag mode=%0d from=%0d", m, s), v & 1, e);
        chk($sformatf("R2 irq_req mode=%0d from=%0d", m, s), int'(irq_req), e);
      end
    end

    // R5: level mode
    wr(0, 1);
    ext_pin = 1'b0;
    step(3);
    chk("R5 level low request", int'(irq_req), 1);
    rd(1, v); chk("R5 level flag zero", v & 1, 0);
    gie = 1'b0;
    step(2);
    chk("R2 gie low blocks request", int'(irq_req), 0);
    gie = 1'b1;
    ext_pin = 1'b1;
    step(3);
    chk("R5 level high no request", int'(irq_req), 0);

    // R4: write-one-to-clear, with ext enable off
    wr(0, 2 << 1);
    step(4);
    wr(1, 1);
    ext_pin = 1'b0;
    step(3);
    rd(1, v); chk("R1 falling edge flag", v & 1, 1);
    chk("R2 ext enable off blocks request", int'(irq_req), 0);
    wr(1, 0); rd(1, v); chk("R4 write zero keeps flag", v & 1, 1);
    wr(1, 1); rd(1, v); chk("R4 write one clears flag", v & 1, 0);

    // R3: acknowledge
    ext_pin = 1'b1; step(4);
    ext_pin = 1'b0; step(3);
    rd(1, v); chk("R3 flag set before ack", v & 1, 1);
    pulse_ack(1); rd(1, v); chk("R3 other vector ack keeps flag", v & 1, 1);
    pulse_ack(0); rd(1, v); chk("R3 matching ack clears flag", v & 1, 0);

    // R7: every pin, every mask/enable combination
    gie = 1'b0;
    for (int p = 0; p < 16; p++) begin
      for (int en = 0; en < 2; en++) begin
        for (int mk = 0; mk < 2; mk++) begin
          int g;
          int b;
          g = p / 8; b = p % 8;
          wr(2 + g, mk << b);
          wr(3 - g, 0);
          wr(0, en << (3 + g));
          wr(1, 7);
          pc_pins[p] = ~pc_pins[p];
          step(3);
          rd(1, v);
          chk($sformatf("R7 pin=%0d en=%0d mask=%0d", p, en, mk), v, (en & mk) << (1 + g));
        end
      end
    end

    // R8: priority and ack sequence
    wr(0, 1 | (3 << 1) | 8 | 16);
    wr(2, 8'hFF); wr(3, 8'hFF);
    step(4);
    wr(1, 7);
    ext_pin = 1'b1;
    pc_pins[0] = ~pc_pins[0];
    pc_pins[8] = ~pc_pins[8];
    step(3);
    rd(1, v); chk("R1 R7 all three flags set", v, 7);
    chk("R2 gie low with pending", int'(irq_req), 0);
    gie = 1'b1;
    step(1);
    chk("R8 request raised", int'(irq_req), 1);
    chk("R8 external first", int'(irq_vec), 0);
    pulse_ack(0); step(1);
    chk("R8 group 0 next", int'(irq_vec), 1);
    pulse_ack(1); step(1);
    chk("R8 group 1 last", int'(irq_vec), 2);
    pulse_ack(2); step(1);
    chk("R3 all acked no request", int'(irq_req), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule